// File: doc/BRIEF.md
# Key-protected watchdog timer

This block is an independent watchdog. A down-counter is paced by a slow tick, which is a one-cycle strobe marking each edge of a separate low-speed clock. A power-of-two prescaler divides that tick. If software does not refresh the counter before it runs out, the block raises a one-cycle system reset. Software reaches the block only through a small word-addressed register port. Sixteen-bit magic words written to the key register open and close write access to the configuration, start the timer and refresh it. Once the timer has started, nothing short of a hardware reset stops it.

Prescaler and reload writes first land in a staging register. They are carried over to the counter only after a fixed number of slow ticks. During that time a busy flag in the status register stays set. A window register can reject refreshes that come too early. A refresh that arrives while the count is still above the window value causes an immediate reset.

The states are as follows. The lock gate has LK_SHUT and LK_OPEN. Each configuration synchroniser has SY_IDLE and SY_BUSY. The counter has WD_STOPPED and WD_RUNNING. The transitions are:
- LK_SHUT to LK_OPEN on the unlock key.
- LK_OPEN to LK_SHUT on the lock key or any undefined key.
- SY_IDLE to SY_BUSY on an accepted write.
- SY_BUSY to SY_BUSY (count restart) on a further write.
- SY_BUSY to SY_IDLE on the last transfer tick.
- WD_STOPPED to WD_RUNNING on the start key.

WD_RUNNING has no exit.

Top module: `wdg_top`

## Requirements
- R1: After reset the timer is stopped, writes are locked and `sys_rst` is 0. Reads return prescaler code 0, reload 0xFFF, status 0 and window 0xFFF.
- R2: The word offsets are fixed: key at 0x00, prescaler at 0x04, reload at 0x08, status at 0x0C, window at 0x10. The key register and any unmapped offset read as 0.
- R3: Key 0x5555 opens writes to the prescaler, reload and window registers. Key 0x0000, or any key other than 0x5555, 0xCCCC and 0xAAAA, closes them. Keys 0xCCCC and 0xAAAA leave the lock state unchanged.
- R4: A prescaler, reload or window write while locked is ignored: the readback is unchanged and no status flag is set.
- R5: The prescaler code sits in bits [3:0]. Code c divides the slow tick by 4·2^c. Codes above 8 saturate at a divide of 1024.
- R6: Key 0xCCCC starts the timer from the active reload value R with divide D. The reset fires on the slow tick numbered (R+1)·D after the start, after which the counter reloads and keeps running.
- R7: While running, no key write stops the timer.
- R8: Key 0xAAAA reloads the counter and clears the prescale phase, so the next timeout comes (R+1)·D ticks later. While the timer is stopped it has no effect.
- R9: Status bit 0 (prescaler) and bit 1 (reload) rise on an accepted write. Each clears on the third slow tick after the latest write to its register, which is when the new value takes effect. A repeated write restarts the count.
- R10: If the window value is not 0xFFF, a refresh while the count is above the window value raises the reset. A refresh at or below the window value does not. A window value of 0xFFF disables the check.
- R11: `sys_rst` is registered. It is high for exactly one clock cycle, in the cycle after the event, and only while the timer runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slow_tick | input | 1 | One-cycle strobe per low-speed clock edge |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Byte offset of the register |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` (combinational) |
| sys_rst | output | 1 | One-cycle system reset request |

## Verification
The assertions assume three things about the inputs. First, `slow_tick` never coincides with a register write. Second, writes are single-cycle strobes. Third, the bus changes its inputs only between clock edges. The bench keeps to this by driving every write and every tick from tasks that hold the strobe for one cycle and release it before the next operation starts. Random reload values and prescaler codes are kept small so that every random timeout can be measured tick by tick.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
    localparam int unsigned KEY_W   = 16;
    localparam int unsigned OFS_KEY = 0;
    localparam int unsigned OFS_PRE = 4;
    localparam int unsigned OFS_RLD = 8;
    localparam int unsigned OFS_STS = 12;
    localparam int unsigned OFS_WIN = 16;

    localparam logic [KEY_W-1:0] KEY_START   = 16'hCCCC;
    localparam logic [KEY_W-1:0] KEY_REFRESH = 16'hAAAA;
    localparam logic [KEY_W-1:0] KEY_OPEN    = 16'h5555;
    localparam logic [KEY_W-1:0] KEY_SHUT    = 16'h0000;

    typedef enum logic {LK_SHUT, LK_OPEN} lock_state_e;
    typedef enum logic {SY_IDLE, SY_BUSY} sync_state_e;
    typedef enum logic {WD_STOPPED, WD_RUNNING} run_state_e;
endpackage

// File: rtl/wdg_keygate.sv
module wdg_keygate
    import wdg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             key_wr,
    input  logic [KEY_W-1:0] key_val,
    output logic             unlocked,
    output logic             start_cmd,
    output logic             refresh_cmd
);
    lock_state_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= LK_SHUT;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        if (key_wr) begin
            unique case (key_val)
                KEY_OPEN:              st_d = LK_OPEN;
                KEY_START, KEY_REFRESH: st_d = st_q;
                default:               st_d = LK_SHUT;
            endcase
        end
    end

    always_comb begin
        unlocked    = (st_q == LK_OPEN);
        start_cmd   = key_wr && (key_val == KEY_START);
        refresh_cmd = key_wr && (key_val == KEY_REFRESH);
    end
endmodule

// File: rtl/wdg_cfg_sync.sv
module wdg_cfg_sync
    import wdg_pkg::*;
#(
    parameter int unsigned W          = 12,
    parameter int unsigned SYNC_TICKS = 3,
    parameter logic [W-1:0] INIT      = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         slow_tick,
    input  logic         wr_en,
    input  logic [W-1:0] wr_val,
    output logic [W-1:0] staged,
    output logic [W-1:0] active,
    output logic         busy
);
    localparam int unsigned CNT_W = $clog2(SYNC_TICKS + 1);

    sync_state_e      st_q, st_d;
    logic [CNT_W-1:0] tcnt_q, tcnt_d;
    logic [W-1:0]     staged_q, staged_d;
    logic [W-1:0]     active_q, active_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= SY_IDLE;
            tcnt_q   <= '0;
            staged_q <= INIT;
            active_q <= INIT;
        end else begin
            st_q     <= st_d;
            tcnt_q   <= tcnt_d;
            staged_q <= staged_d;
            active_q <= active_d;
        end
    end

    always_comb begin
        st_d     = st_q;
        tcnt_d   = tcnt_q;
        staged_d = staged_q;
        active_d = active_q;
        unique case (st_q)
            SY_IDLE: begin
                if (wr_en) begin
                    staged_d = wr_val;
                    tcnt_d   = '0;
                    st_d     = SY_BUSY;
                end
            end
            SY_BUSY: begin
                if (wr_en) begin
                    staged_d = wr_val;
                    tcnt_d   = '0;
                end else if (slow_tick) begin
                    if (tcnt_q == CNT_W'(SYNC_TICKS - 1)) begin
                        active_d = staged_q;
                        tcnt_d   = '0;
                        st_d     = SY_IDLE;
                    end else begin
                        tcnt_d = tcnt_q + 1'b1;
                    end
                end
            end
            default: st_d = SY_IDLE;
        endcase
    end

    always_comb begin
        staged = staged_q;
        active = active_q;
        busy   = (st_q == SY_BUSY);
    end
endmodule

// File: rtl/wdg_counter.sv
module wdg_counter
    import wdg_pkg::*;
#(
    parameter int unsigned CNT_W     = 12,
    parameter int unsigned CODE_W    = 4,
    parameter int unsigned MIN_SHIFT = 2,
    parameter int unsigned MAX_CODE  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_tick,
    input  logic              start_cmd,
    input  logic              refresh_cmd,
    input  logic [CNT_W-1:0]  reload,
    input  logic [CNT_W-1:0]  window,
    input  logic [CODE_W-1:0] code,
    output logic              running,
    output logic              sys_rst
);
    localparam int unsigned DIV_W = MIN_SHIFT + MAX_CODE;

    run_state_e        st_q, st_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [DIV_W-1:0]  pdiv_q, pdiv_d;
    logic              rst_q;
    logic              fire;
    logic [CODE_W-1:0] code_eff;
    logic [DIV_W-1:0]  div_last;
    logic              win_on;
    logic [DIV_W-1:0]  last_tab [MAX_CODE+1];

    for (genvar g = 0; g <= MAX_CODE; g++) begin : g_div
        assign last_tab[g] = DIV_W'((1 << (MIN_SHIFT + g)) - 1);
    end

    assign code_eff = (code > CODE_W'(MAX_CODE)) ? CODE_W'(MAX_CODE) : code;
    assign div_last = last_tab[code_eff];
    assign win_on   = (window != '1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= WD_STOPPED;
            cnt_q  <= '1;
            pdiv_q <= '0;
            rst_q  <= 1'b0;
        end else begin
            st_q   <= st_d;
            cnt_q  <= cnt_d;
            pdiv_q <= pdiv_d;
            rst_q  <= fire;
        end
    end

    always_comb begin
        st_d   = st_q;
        cnt_d  = cnt_q;
        pdiv_d = pdiv_q;
        fire   = 1'b0;
        unique case (st_q)
            WD_STOPPED: begin
                if (start_cmd) begin
                    st_d   = WD_RUNNING;
                    cnt_d  = reload;
                    pdiv_d = '0;
                end
            end
            WD_RUNNING: begin
                if (refresh_cmd) begin
                    fire   = win_on && (cnt_q > window);
                    cnt_d  = reload;
                    pdiv_d = '0;
                end else if (slow_tick) begin
                    if (pdiv_q >= div_last) begin
                        pdiv_d = '0;
                        if (cnt_q == '0) begin
                            fire  = 1'b1;
                            cnt_d = reload;
                        end else begin
                            cnt_d = cnt_q - 1'b1;
                        end
                    end else begin
                        pdiv_d = pdiv_q + 1'b1;
                    end
                end
            end
            default: st_d = WD_STOPPED;
        endcase
    end

    always_comb begin
        running = (st_q == WD_RUNNING);
        sys_rst = rst_q;
    end
endmodule

// File: rtl/wdg_top.sv
module wdg_top
    import wdg_pkg::*;
#(
    parameter int unsigned DATA_W     = 16,
    parameter int unsigned ADDR_W     = 5,
    parameter int unsigned RELOAD_W   = 12,
    parameter int unsigned CODE_W     = 4,
    parameter int unsigned MIN_SHIFT  = 2,
    parameter int unsigned MAX_CODE   = 8,
    parameter int unsigned SYNC_TICKS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              sys_rst
);
    logic sel_key, sel_pre, sel_rld, sel_sts, sel_win;
    logic unlocked, start_cmd, refresh_cmd, running;
    logic pre_busy, rld_busy;
    logic [CODE_W-1:0]   pre_staged, pre_active;
    logic [RELOAD_W-1:0] rld_staged, rld_active;
    logic [RELOAD_W-1:0] window_q;

    assign sel_key = (addr == ADDR_W'(OFS_KEY));
    assign sel_pre = (addr == ADDR_W'(OFS_PRE));
    assign sel_rld = (addr == ADDR_W'(OFS_RLD));
    assign sel_sts = (addr == ADDR_W'(OFS_STS));
    assign sel_win = (addr == ADDR_W'(OFS_WIN));

    wdg_keygate u_key (
        .clk         (clk),
        .rst_n       (rst_n),
        .key_wr      (wr_en && sel_key),
        .key_val     (wdata[KEY_W-1:0]),
        .unlocked    (unlocked),
        .start_cmd   (start_cmd),
        .refresh_cmd (refresh_cmd)
    );

    wdg_cfg_sync #(.W(CODE_W), .SYNC_TICKS(SYNC_TICKS), .INIT('0)) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .slow_tick (slow_tick),
        .wr_en     (wr_en && sel_pre && unlocked),
        .wr_val    (wdata[CODE_W-1:0]),
        .staged    (pre_staged),
        .active    (pre_active),
        .busy      (pre_busy)
    );

    wdg_cfg_sync #(.W(RELOAD_W), .SYNC_TICKS(SYNC_TICKS), .INIT('1)) u_rld (
        .clk       (clk),
        .rst_n     (rst_n),
        .slow_tick (slow_tick),
        .wr_en     (wr_en && sel_rld && unlocked),
        .wr_val    (wdata[RELOAD_W-1:0]),
        .staged    (rld_staged),
        .active    (rld_active),
        .busy      (rld_busy)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           window_q <= '1;
        else if (wr_en && sel_win && unlocked) window_q <= wdata[RELOAD_W-1:0];
    end

    wdg_counter #(
        .CNT_W(RELOAD_W), .CODE_W(CODE_W),
        .MIN_SHIFT(MIN_SHIFT), .MAX_CODE(MAX_CODE)
    ) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .slow_tick   (slow_tick),
        .start_cmd   (start_cmd),
        .refresh_cmd (refresh_cmd),
        .reload      (rld_active),
        .window      (window_q),
        .code        (pre_active),
        .running     (running),
        .sys_rst     (sys_rst)
    );

    always_comb begin
        rdata = '0;
        if (sel_pre)      rdata = DATA_W'(pre_staged);
        else if (sel_rld) rdata = DATA_W'(rld_staged);
        else if (sel_sts) rdata = DATA_W'({rld_busy, pre_busy});
        else if (sel_win) rdata = DATA_W'(window_q);
    end
endmodule

// File: rtl/wdg_chk.sv
module wdg_chk
    import wdg_pkg::*;
#(
    parameter int unsigned ADDR_W = 5,
    parameter int unsigned DATA_W = 16,
    parameter int unsigned CODE_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic              sys_rst,
    input logic              running,
    input logic              unlocked,
    input logic              pre_busy,
    input logic              rld_busy,
    input logic [CODE_W-1:0] pre_staged
);
    // R7
    run_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        running |=> running);

    // R4
    locked_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(OFS_PRE) && !unlocked) |=> $stable(pre_staged));

    // R9
    pre_busy_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pre_busy) |-> $past(wr_en && addr == ADDR_W'(OFS_PRE) && unlocked));

    // R9
    rld_busy_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rld_busy) |-> $past(wr_en && addr == ADDR_W'(OFS_RLD) && unlocked));

    // R11
    rst_when_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst |-> $past(running));

    // R3
    unlock_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(OFS_KEY) && wdata[KEY_W-1:0] == KEY_OPEN) |=> unlocked);
endmodule

bind wdg_top wdg_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CODE_W(CODE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .addr       (addr),
    .wdata      (wdata),
    .sys_rst    (sys_rst),
    .running    (running),
    .unlocked   (unlocked),
    .pre_busy   (pre_busy),
    .rld_busy   (rld_busy),
    .pre_staged (pre_staged)
);

// File: tb/wdg_top_tb.sv
module wdg_top_tb;
    localparam logic [4:0] A_KEY = 5'h00, A_PRE = 5'h04, A_RLD = 5'h08,
                           A_STS = 5'h0C, A_WIN = 5'h10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slow_tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        sys_rst;
    logic        last_rst;
    int          checks = 0;
    int          errors = 0;

    always #4 clk = ~clk;

    wdg_top u_dut (
        .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .sys_rst(sys_rst)
    );

    function automatic int exp_div(input int code);
        return (code > 8) ? 1024 : (4 << code);
    endfunction

    function automatic int exp_ticks(input int rl, input int code);
        return (rl + 1) * exp_div(code);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0; last_rst = sys_rst;
    endtask

    task automatic rd(input logic [4:0] a, output logic [15:0] v);
        @(negedge clk); addr = a; #1; v = rdata;
    endtask

    task automatic tick(output logic r);
        @(negedge clk); slow_tick = 1'b1;
        @(negedge clk); slow_tick = 1'b0; r = sys_rst;
    endtask

    task automatic ticks(input int n, output int fired);
        logic r;
        fired = 0;
        for (int i = 0; i < n; i++) begin tick(r); if (r) fired++; end
    endtask

    // count ticks until a reset; checks the pulse ends next cycle (R11)
    task automatic measure(input int max, output int n);
        logic r;
        n = -1;
        for (int i = 1; i <= max; i++) begin
            tick(r);
            if (r) begin n = i; break; end
        end
        @(negedge clk);
        chk(sys_rst == 1'b0, "R11 pulse width", int'(sys_rst), 0);
    endtask

    task automatic settle();
        logic [15:0] v; logic r;
        rd(A_STS, v);
        while (v != 0) begin tick(r); rd(A_STS, v); end
    endtask

    task automatic cfg(input int code, input int rl);
        wr(A_KEY, 16'h5555);
        wr(A_PRE, 16'(code));
        wr(A_RLD, 16'(rl));
        wr(A_KEY, 16'h0000);
        settle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] v;
        int n, f, code, rl;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 / R2 reset state and map
        rd(A_PRE, v); chk(v == 16'h0, "R1 prescaler reset", v, 0);
        rd(A_RLD, v); chk(v == 16'hFFF, "R1 reload reset", v, 16'hFFF);
        rd(A_STS, v); chk(v == 16'h0, "R1 status reset", v, 0);
        rd(A_WIN, v); chk(v == 16'hFFF, "R1 window reset", v, 16'hFFF);
        chk(sys_rst == 1'b0, "R1 sys_rst idle", int'(sys_rst), 0);
        rd(A_KEY, v); chk(v == 16'h0, "R2 key reads zero", v, 0);
        rd(5'h14, v); chk(v == 16'h0, "R2 unmapped reads zero", v, 0);

        // R8 refresh while stopped does nothing
        wr(A_KEY, 16'hAAAA);
        ticks(40, f); chk(f == 0, "R8 stopped refresh", f, 0);

        // R4 locked writes ignored
        wr(A_PRE, 16'h3); wr(A_RLD, 16'h5); wr(A_WIN, 16'h7);
        rd(A_PRE, v); chk(v == 16'h0, "R4 locked prescaler", v, 0);
        rd(A_RLD, v); chk(v == 16'hFFF, "R4 locked reload", v, 16'hFFF);
        rd(A_WIN, v); chk(v == 16'hFFF, "R4 locked window", v, 16'hFFF);
        rd(A_STS, v); chk(v == 16'h0, "R4 no busy", v, 0);

        // R3 lock behaviour
        wr(A_KEY, 16'h5555); wr(A_PRE, 16'h1);
        rd(A_PRE, v); chk(v == 16'h1, "R3 open write", v, 1);
        wr(A_KEY, 16'h1234); wr(A_PRE, 16'h2);
        rd(A_PRE, v); chk(v == 16'h1, "R3 undefined key locks", v, 1);
        wr(A_KEY, 16'h5555); wr(A_KEY, 16'hAAAA); wr(A_RLD, 16'h3);
        rd(A_RLD, v); chk(v == 16'h3, "R3 refresh key keeps open", v, 3);

        // R9 busy flags
        rd(A_STS, v); chk(v == 16'h3, "R9 both busy", v, 3);
        ticks(2, f); rd(A_STS, v); chk(v == 16'h3, "R9 busy after 2 ticks", v, 3);
        ticks(1, f); rd(A_STS, v); chk(v == 16'h0, "R9 clear after 3 ticks", v, 0);
        wr(A_PRE, 16'h0); ticks(2, f); wr(A_PRE, 16'h0); ticks(2, f);
        rd(A_STS, v); chk(v == 16'h1, "R9 rewrite restarts", v, 1);
        ticks(1, f); rd(A_STS, v); chk(v == 16'h0, "R9 restart clears", v, 0);
        wr(A_KEY, 16'h0000);

        // R6 start and auto reload (reload 3, divide 4)
        wr(A_KEY, 16'hCCCC);
        measure(200, n); chk(n == exp_ticks(3, 0), "R6 first timeout", n, exp_ticks(3, 0));
        measure(200, n); chk(n == exp_ticks(3, 0), "R6 periodic timeout", n, exp_ticks(3, 0));

        // R7 no key stops it
        wr(A_KEY, 16'h0000); wr(A_KEY, 16'h1234); wr(A_KEY, 16'hFFFF); wr(A_KEY, 16'hCCCC);
        measure(200, n); chk(n == exp_ticks(3, 0), "R7 still running", n, exp_ticks(3, 0));

        // R8 refresh mid-count
        ticks(10, f);
        wr(A_KEY, 16'hAAAA);
        chk(last_rst == 1'b0, "R8 refresh no reset", int'(last_rst), 0);
        measure(200, n); chk(n == exp_ticks(3, 0), "R8 refresh restarts", n, exp_ticks(3, 0));

        // R5 directed saturation and top code
        cfg(12, 0); wr(A_KEY, 16'hAAAA);
        rd(A_PRE, v); chk(v == 16'd12, "R5 code readback", v, 12);
        measure(3000, n); chk(n == exp_ticks(0, 12), "R5 saturated divide", n, exp_ticks(0, 12));
        cfg(8, 1); wr(A_KEY, 16'hAAAA);
        measure(3000, n); chk(n == exp_ticks(1, 8), "R5 divide 1024", n, exp_ticks(1, 8));

        // R5 / R6 random trials
        for (int t = 0; t < 10; t++) begin
            code = int'($urandom % 3);
            rl   = int'($urandom % 12);
            cfg(code, rl); wr(A_KEY, 16'hAAAA);
            measure(400, n);
            chk(n == exp_ticks(rl, code), "R5 random timeout", n, exp_ticks(rl, code));
        end

        // R10 window
        cfg(0, 20);
        wr(A_KEY, 16'hAAAA);
        chk(last_rst == 1'b0, "R10 window off", int'(last_rst), 0);
        wr(A_KEY, 16'h5555); wr(A_WIN, 16'd5); wr(A_KEY, 16'h0000);
        wr(A_KEY, 16'hAAAA);
        chk(last_rst == 1'b1, "R10 early refresh", int'(last_rst), 1);
        ticks(60, f); chk(f == 0, "R10 no timeout yet", f, 0);
        wr(A_KEY, 16'hAAAA);
        chk(last_rst == 1'b0, "R10 refresh at window", int'(last_rst), 0);
        ticks(56, f);
        wr(A_KEY, 16'hAAAA);
        chk(last_rst == 1'b1, "R10 one above window", int'(last_rst), 1);
        wr(A_KEY, 16'h5555); wr(A_WIN, 16'hFFF); wr(A_KEY, 16'h0000);
        wr(A_KEY, 16'hAAAA);
        chk(last_rst == 1'b0, "R10 window disabled", int'(last_rst), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule